// File: doc/BRIEF.md
# SCSI Bus Controller Register Block

This block is the register set that a host processor sees when it controls a narrow (8-bit) SCSI bus. The host reaches it over a small bus with a 3-bit address, an 8-bit data path and separate read and write strobes. A read and a write to the same address often reach different registers. For example, a write at address 0 loads the data latch that goes out to the bus, while a read at address 0 returns the live bus data lines.

The block holds three control registers: the initiator command bits, the target command bits and a mode register. It turns them into per-line assert requests for the SCSI control lines and into a data drive enable. It registers the bus lines once per clock and reports them as status. It computes phase match against the target command register and checks odd parity on incoming bytes. It latches parity and busy-loss errors and raises one interrupt for selection, parity error or unexpected loss of BSY. A read at address 7 clears the latched interrupt state.

The bus is modelled as separate input, output and assert-enable signals. Arbitration timing, DMA handshaking and differential drivers are outside this block.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset, every register reads zero, `ctl_oe` is 0, `dat_oe` is 0 and `irq` is low.
- R2: A write at address 0 loads the outgoing data latch shown on `dat_out`. A read at address 0 or address 6 returns the bus data lines as registered on the previous clock, not the latch.
- R3: A write at address 1 sets the initiator bits: bit7 RST, bit4 ACK, bit3 BSY, bit2 SEL, bit1 ATN, bit0 data enable. RST, BSY and SEL drive `ctl_oe` bits 8, 7 and 6 directly. Written bits 6 and 5 are dropped. A read returns the stored bits with the arbitration flags in bits 6 and 5.
- R4: `dat_oe` is high when mode bit0 (arbitrate) is set, or when the data-enable bit is set and the sampled phase lines equal the target command bits. `par_out` makes the nine bits `{dat_out,par_out}` hold an odd count of ones.
- R5: The `ctl_oe` bits are: 8 RST, 7 BSY, 6 SEL, 5 REQ, 4 ACK, 3 ATN, 2 MSG, 1 C/D, 0 I/O. `ctl_in` uses the same positions. REQ, MSG, C/D and I/O follow target command bits 3..0 only while mode bit6 (target) is set. ACK and ATN follow the initiator bits only while mode bit6 is clear.
- R6: A read at address 4 returns the sampled lines in this order: bit7 RST, bit6 BSY, bit5 REQ, bit4 MSG, bit3 C/D, bit2 I/O, bit1 SEL, bit0 data parity.
- R7: Bit3 of a read at address 5 is set exactly when the sampled MSG, C/D and I/O lines equal target command bits 2:0. The phase codes as MSG,C/D,I/O are: data out 000, data in 001, command 010, status 011, message out 110, message in 111. Bits 1 and 0 of the same read show the sampled ATN and ACK lines.
- R8: A write at address 4 sets the selection mask. The interrupt is raised when sampled BSY is low, sampled SEL is high and some sampled data bit is set that is also set in the mask.
- R9: While mode bit5 is set, a rising edge of sampled REQ on a byte whose data and parity bits hold an even count of ones sets the parity error flag (address 5 bit5). The flag stays set until cleared. The same event raises the interrupt only if mode bit4 is set. With mode bit5 clear, no error is recorded.
- R10: While mode bit2 is set, a falling edge of sampled BSY sets the busy error flag (address 5 bit2) and raises the interrupt. With mode bit2 clear, nothing is recorded.
- R11: A read at address 7 clears the interrupt, the parity error flag and the busy error flag, unless a new setting event occurs in the same cycle. Address 5 bit4 mirrors `irq`.
- R12: Initiator read bit6 is set while mode bit0 is set and sampled BSY is high. Initiator read bit5 latches when sampled SEL is high while mode bit0 is set and this block's own SEL bit is clear. It clears once mode bit0 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (address 7 clears flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Latched interrupt |
| dat_in | input | 8 | SCSI data lines as seen on the bus |
| par_in | input | 1 | SCSI data parity line |
| dat_out | output | 8 | Outgoing data latch |
| par_out | output | 1 | Odd parity of `dat_out` |
| dat_oe | output | 1 | Data and parity drive enable |
| ctl_in | input | 9 | SCSI control lines, active high |
| ctl_oe | output | 9 | Per-line assert request for control lines |

## Verification
The bench targets the places where a same-address read and write could be confused. It checks that address 0 returns the bus lines and not the latch, and that address 4 returns status and not the selection mask. It steps through all six phase codes with matching and off-by-one bus phases, because a wrong bit order in the phase compare would flag a match that does not exist. Parity checking is tested as good byte, bad byte with interrupt, bad byte without interrupt, and checking disabled; a design using even parity or ignoring the enable bits would latch the wrong flag. The clear-on-read path is checked after each latched event, and arbitration-lost is checked for holding after SEL goes away and for dropping only when the arbitrate bit is cleared.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CW = 9;

  // control line positions in ctl_in / ctl_oe
  localparam int C_IO  = 0;
  localparam int C_CD  = 1;
  localparam int C_MSG = 2;
  localparam int C_ATN = 3;
  localparam int C_ACK = 4;
  localparam int C_REQ = 5;
  localparam int C_SEL = 6;
  localparam int C_BSY = 7;
  localparam int C_RST = 8;

  // stored initiator bits (compressed: written bits 6 and 5 dropped)
  localparam int IW    = 6;
  localparam int I_DEN = 0;
  localparam int I_ATN = 1;
  localparam int I_SEL = 2;
  localparam int I_BSY = 3;
  localparam int I_ACK = 4;
  localparam int I_RST = 5;

  // mode bits
  localparam int MW     = 7;
  localparam int M_ARB  = 0;
  localparam int M_DMA  = 1;
  localparam int M_MBSY = 2;
  localparam int M_EOPI = 3;
  localparam int M_PINT = 4;
  localparam int M_PCHK = 5;
  localparam int M_TGT  = 6;

  localparam int TW = 4;

  localparam logic [AW-1:0] A_DATA  = 3'd0;
  localparam logic [AW-1:0] A_ICMD  = 3'd1;
  localparam logic [AW-1:0] A_MODE  = 3'd2;
  localparam logic [AW-1:0] A_TCMD  = 3'd3;
  localparam logic [AW-1:0] A_STAT  = 3'd4;
  localparam logic [AW-1:0] A_BSTAT = 3'd5;
  localparam logic [AW-1:0] A_INDAT = 3'd6;
  localparam logic [AW-1:0] A_CLR   = 3'd7;

  // parity bit that gives an odd count of ones over data plus parity
  function automatic logic odd_par_bit(input logic [DW-1:0] d);
    return ~(^d);
  endfunction

  // true when data plus parity hold an odd count of ones
  function automatic logic odd_ok(input logic [DW-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic phase_eq(input logic msg, input logic cd, input logic io,
                                    input logic [2:0] want);
    return {msg, cd, io} == want;
  endfunction
endpackage

// File: rtl/scsi_ctl_bank.sv
module scsi_ctl_bank
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] odr_q,
  output logic [IW-1:0] icmd_q,
  output logic [MW-1:0] mode_q,
  output logic [TW-1:0] tcmd_q,
  output logic [DW-1:0] selmask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odr_q     <= '0;
      icmd_q    <= '0;
      mode_q    <= '0;
      tcmd_q    <= '0;
      selmask_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: odr_q     <= wdata;
        A_ICMD: icmd_q    <= {wdata[7], wdata[4:0]};
        A_MODE: mode_q    <= wdata[MW-1:0];
        A_TCMD: tcmd_q    <= wdata[TW-1:0];
        A_STAT: selmask_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_bus_sampler.sv
module scsi_bus_sampler
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dat_in,
  input  logic          par_in,
  input  logic [CW-1:0] ctl_in,
  output logic [DW-1:0] s_dat,
  output logic          s_par,
  output logic [CW-1:0] s_ctl,
  output logic          req_rise,
  output logic          bsy_fall
);
  logic req_d, bsy_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_dat <= '0;
      s_par <= 1'b0;
      s_ctl <= '0;
      req_d <= 1'b0;
      bsy_d <= 1'b0;
    end else begin
      s_dat <= dat_in;
      s_par <= par_in;
      s_ctl <= ctl_in;
      req_d <= s_ctl[C_REQ];
      bsy_d <= s_ctl[C_BSY];
    end
  end

  assign req_rise = s_ctl[C_REQ] & ~req_d;
  assign bsy_fall = ~s_ctl[C_BSY] & bsy_d;
endmodule

// File: rtl/scsi_event_unit.sv
module scsi_event_unit
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] s_dat,
  input  logic          s_par,
  input  logic          s_msg,
  input  logic          s_cd,
  input  logic          s_io,
  input  logic          s_bsy,
  input  logic          s_sel,
  input  logic          req_rise,
  input  logic          bsy_fall,
  input  logic [2:0]    phase_want,
  input  logic [DW-1:0] selmask,
  input  logic          own_sel,
  input  logic          en_pchk,
  input  logic          en_pint,
  input  logic          en_mbsy,
  input  logic          arb_on,
  input  logic          clr,
  output logic          phase_match,
  output logic          sel_hit,
  output logic          par_evt,
  output logic          bsy_evt,
  output logic          par_err,
  output logic          bsy_err,
  output logic          irq,
  output logic          arb_busy,
  output logic          arb_lost
);
  logic irq_set;

  assign phase_match = phase_eq(s_msg, s_cd, s_io, phase_want);
  assign sel_hit     = ~s_bsy & s_sel & (|(s_dat & selmask));
  assign par_evt     = en_pchk & req_rise & ~odd_ok(s_dat, s_par);
  assign bsy_evt     = en_mbsy & bsy_fall;
  assign irq_set     = sel_hit | (par_evt & en_pint) | bsy_evt;
  assign arb_busy    = arb_on & s_bsy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_err  <= 1'b0;
      bsy_err  <= 1'b0;
      irq      <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      if (par_evt)      par_err <= 1'b1;
      else if (clr)     par_err <= 1'b0;
      if (bsy_evt)      bsy_err <= 1'b1;
      else if (clr)     bsy_err <= 1'b0;
      if (irq_set)      irq <= 1'b1;
      else if (clr)     irq <= 1'b0;
      if (!arb_on)                arb_lost <= 1'b0;
      else if (s_sel && !own_sel) arb_lost <= 1'b1;
    end
  end
endmodule

// File: rtl/scsi_drive_unit.sv
module scsi_drive_unit
  import scsi_ctl_pkg::*;
(
  input  logic [DW-1:0] odr,
  input  logic [IW-1:0] icmd,
  input  logic          tgt,
  input  logic          arb_on,
  input  logic [TW-1:0] tcmd,
  input  logic          phase_match,
  output logic [DW-1:0] dat_out,
  output logic          par_out,
  output logic          dat_oe,
  output logic [CW-1:0] ctl_oe
);
  assign dat_out = odr;
  assign par_out = odd_par_bit(odr);
  assign dat_oe  = arb_on | (icmd[I_DEN] & phase_match);

  always_comb begin
    ctl_oe        = '0;
    ctl_oe[C_RST] = icmd[I_RST];
    ctl_oe[C_BSY] = icmd[I_BSY];
    ctl_oe[C_SEL] = icmd[I_SEL];
    ctl_oe[C_ACK] = icmd[I_ACK] & ~tgt;
    ctl_oe[C_ATN] = icmd[I_ATN] & ~tgt;
    ctl_oe[C_REQ] = tcmd[3] & tgt;
    ctl_oe[C_MSG] = tcmd[2] & tgt;
    ctl_oe[C_CD]  = tcmd[1] & tgt;
    ctl_oe[C_IO]  = tcmd[0] & tgt;
  end
endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic [DW-1:0] dat_in,
  input  logic          par_in,
  output logic [DW-1:0] dat_out,
  output logic          par_out,
  output logic          dat_oe,
  input  logic [CW-1:0] ctl_in,
  output logic [CW-1:0] ctl_oe
);
  logic [DW-1:0] odr_q, selmask_q, s_dat;
  logic [IW-1:0] icmd_q;
  logic [MW-1:0] mode_q;
  logic [TW-1:0] tcmd_q;
  logic [CW-1:0] s_ctl;
  logic          s_par, req_rise, bsy_fall;
  logic          phase_match, sel_hit, par_evt, bsy_evt;
  logic          par_err, bsy_err, arb_busy, arb_lost;
  logic          clr_rd;

  assign clr_rd = rd_en & (addr == A_CLR);

  scsi_ctl_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .odr_q(odr_q), .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q),
    .selmask_q(selmask_q)
  );

  scsi_bus_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .dat_in(dat_in), .par_in(par_in), .ctl_in(ctl_in),
    .s_dat(s_dat), .s_par(s_par), .s_ctl(s_ctl),
    .req_rise(req_rise), .bsy_fall(bsy_fall)
  );

  scsi_event_unit u_evt (
    .clk(clk), .rst_n(rst_n), .s_dat(s_dat), .s_par(s_par),
    .s_msg(s_ctl[C_MSG]), .s_cd(s_ctl[C_CD]), .s_io(s_ctl[C_IO]),
    .s_bsy(s_ctl[C_BSY]), .s_sel(s_ctl[C_SEL]),
    .req_rise(req_rise), .bsy_fall(bsy_fall),
    .phase_want(tcmd_q[2:0]), .selmask(selmask_q), .own_sel(icmd_q[I_SEL]),
    .en_pchk(mode_q[M_PCHK]), .en_pint(mode_q[M_PINT]), .en_mbsy(mode_q[M_MBSY]),
    .arb_on(mode_q[M_ARB]), .clr(clr_rd),
    .phase_match(phase_match), .sel_hit(sel_hit), .par_evt(par_evt),
    .bsy_evt(bsy_evt), .par_err(par_err), .bsy_err(bsy_err), .irq(irq),
    .arb_busy(arb_busy), .arb_lost(arb_lost)
  );

  scsi_drive_unit u_drv (
    .odr(odr_q), .icmd(icmd_q), .tgt(mode_q[M_TGT]), .arb_on(mode_q[M_ARB]),
    .tcmd(tcmd_q), .phase_match(phase_match),
    .dat_out(dat_out), .par_out(par_out), .dat_oe(dat_oe), .ctl_oe(ctl_oe)
  );

  always_comb begin
    case (addr)
      A_DATA, A_INDAT: rdata = s_dat;
      A_ICMD:  rdata = {icmd_q[I_RST], arb_busy, arb_lost, icmd_q[I_ACK:I_DEN]};
      A_MODE:  rdata = {1'b0, mode_q};
      A_TCMD:  rdata = {{(DW-TW){1'b0}}, tcmd_q};
      A_STAT:  rdata = {s_ctl[C_RST], s_ctl[C_BSY], s_ctl[C_REQ], s_ctl[C_MSG],
                        s_ctl[C_CD], s_ctl[C_IO], s_ctl[C_SEL], s_par};
      A_BSTAT: rdata = {2'b00, par_err, irq, phase_match, bsy_err,
                        s_ctl[C_ATN], s_ctl[C_ACK]};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/scsi_ctl_regs_chk.sv
module scsi_ctl_regs_chk
  import scsi_ctl_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic [CW-1:0] ctl_oe,
  input logic          dat_oe,
  input logic [DW-1:0] dat_out,
  input logic          par_out,
  input logic          irq,
  input logic [MW-1:0] mode_q,
  input logic [IW-1:0] icmd_q,
  input logic          phase_match,
  input logic          sel_hit,
  input logic          par_evt,
  input logic          bsy_evt,
  input logic          par_err,
  input logic          arb_lost
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_oe == '0 && !dat_oe && !irq));

  p_drive_reason_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && !mode_q[M_ARB]) |-> (icmd_q[I_DEN] && phase_match));

  p_odd_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> (^{dat_out, par_out}));

  p_target_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[M_TGT] |-> (!ctl_oe[C_REQ] && !ctl_oe[C_MSG] && !ctl_oe[C_CD] && !ctl_oe[C_IO]));

  p_init_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[M_TGT] |-> (!ctl_oe[C_ACK] && !ctl_oe[C_ATN]));

  p_sel_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> irq);

  p_par_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> par_err);

  p_busy_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_evt |=> irq);

  p_clear_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CLR && !sel_hit && !bsy_evt && !par_evt) |=> (!irq && !par_err));

  p_arb_lost_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[M_ARB] |=> !arb_lost);
endmodule

bind scsi_ctl_regs scsi_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .ctl_oe(ctl_oe),
  .dat_oe(dat_oe), .dat_out(dat_out), .par_out(par_out), .irq(irq),
  .mode_q(mode_q), .icmd_q(icmd_q), .phase_match(phase_match),
  .sel_hit(sel_hit), .par_evt(par_evt), .bsy_evt(bsy_evt),
  .par_err(par_err), .arb_lost(arb_lost)
);

// File: tb/scsi_ctl_regs_bench.sv
module scsi_ctl_regs_bench;
  // bench-side line positions (R5)
  localparam int L_IO = 0, L_CD = 1, L_MSG = 2, L_ATN = 3, L_ACK = 4;
  localparam int L_REQ = 5, L_SEL = 6, L_BSY = 7, L_RST = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;
  logic [7:0] dat_in = '0, dat_out;
  logic       par_in = 1'b0, par_out, dat_oe;
  logic [8:0] ctl_in = '0, ctl_oe;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  scsi_ctl_regs u_scsi_ctl_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .dat_in(dat_in), .par_in(par_in),
    .dat_out(dat_out), .par_out(par_out), .dat_oe(dat_oe),
    .ctl_in(ctl_in), .ctl_oe(ctl_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic bus(input logic [8:0] c, input logic [7:0] d, input logic p);
    @(negedge clk); ctl_in = c; dat_in = d; par_in = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1", "ctl_oe", ctl_oe, 0);
    chk("R1", "dat_oe", dat_oe, 0);
    chk("R1", "irq", irq, 0);
    for (int a = 1; a < 6; a++) begin
      rd(a[2:0], v);
      chk("R1", $sformatf("reg %0d", a), v, (a == 5) ? 16'h08 : 16'h00); // phase 000 matches tcr 0
    end
  endtask

  task automatic t_data_regs;
    logic [7:0] v;
    wr(3'd0, 8'hA5);
    bus(9'h000, 8'h3C, 1'b0);
    rd(3'd0, v);
    chk("R2", "addr0 read is bus", v, 8'h3C);
    chk("R2", "dat_out latch", dat_out, 8'hA5);
    rd(3'd6, v);
    chk("R2", "addr6 read is bus", v, 8'h3C);
    bus(9'h000, 8'h00, 1'b0);
  endtask

  task automatic t_icmd;
    logic [7:0] v;
    wr(3'd1, 8'h8E);
    chk("R3", "ctl_oe rst/bsy/sel/atn", ctl_oe,
        (1 << L_RST) | (1 << L_BSY) | (1 << L_SEL) | (1 << L_ATN));
    rd(3'd1, v);
    chk("R3", "icmd readback", v, 8'h8E);
    wr(3'd1, 8'h60);
    rd(3'd1, v);
    chk("R3", "bits 6,5 dropped", v, 8'h00);
    chk("R3", "ctl_oe cleared", ctl_oe, 0);
  endtask

  task automatic t_drive;
    wr(3'd0, 8'hA5);
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h01);
    bus(9'h001 << L_IO, 8'h00, 1'b0);
    chk("R4", "dat_oe on phase match", dat_oe, 1);
    chk("R4", "odd parity of A5", {dat_out, par_out}, {8'hA5, 1'b1});
    bus(9'h001 << L_CD, 8'h00, 1'b0);
    chk("R4", "dat_oe off on mismatch", dat_oe, 0);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01);
    chk("R4", "dat_oe during arbitrate", dat_oe, 1);
    wr(3'd0, 8'h07);
    chk("R4", "odd parity of 07", par_out, 0);
    wr(3'd2, 8'h00);
    chk("R4", "dat_oe released", dat_oe, 0);
    wr(3'd3, 8'h00);
    bus(9'h000, 8'h00, 1'b0);
  endtask

  task automatic t_target;
    wr(3'd2, 8'h40);
    wr(3'd3, 8'h0F);
    wr(3'd1, 8'h12);
    chk("R5", "target lines driven, ack/atn held", ctl_oe,
        (1 << L_REQ) | (1 << L_MSG) | (1 << L_CD) | (1 << L_IO));
    wr(3'd2, 8'h00);
    chk("R5", "initiator ack/atn, target lines off", ctl_oe, (1 << L_ACK) | (1 << L_ATN));
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    bus((1 << L_BSY) | (1 << L_MSG) | (1 << L_IO), 8'h00, 1'b1);
    rd(3'd4, v);
    chk("R6", "status bsy/msg/io/dbp", v, 8'h55);
    bus((1 << L_RST) | (1 << L_REQ) | (1 << L_CD) | (1 << L_SEL), 8'h00, 1'b0);
    rd(3'd4, v);
    chk("R6", "status rst/req/cd/sel", v, 8'hAA);
    bus(9'h000, 8'h00, 1'b0);
  endtask

  task automatic t_phase;
    logic [7:0] v;
    logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
    for (int i = 0; i < 6; i++) begin
      wr(3'd3, {5'b0, codes[i]});
      bus({6'b0, codes[i]}, 8'h00, 1'b0);
      rd(3'd5, v);
      chk("R7", $sformatf("match code %0d", codes[i]), v[3], 1);
      bus({6'b0, codes[i] ^ 3'b001}, 8'h00, 1'b0);
      rd(3'd5, v);
      chk("R7", $sformatf("no match code %0d", codes[i]), v[3], 0);
    end
    bus((1 << L_ATN), 8'h00, 1'b0);
    rd(3'd5, v);
    chk("R7", "atn/ack bits", v[1:0], 2'b10);
    bus((1 << L_ACK), 8'h00, 1'b0);
    rd(3'd5, v);
    chk("R7", "ack bit", v[1:0], 2'b01);
    wr(3'd3, 8'h00);
    bus(9'h000, 8'h00, 1'b0);
  endtask

  task automatic t_select;
    logic [7:0] v;
    wr(3'd4, 8'h04);
    bus((1 << L_SEL), 8'h08, 1'b0);
    chk("R8", "no irq outside mask", irq, 0);
    bus((1 << L_SEL) | (1 << L_BSY), 8'h04, 1'b0);
    chk("R8", "no irq while BSY", irq, 0);
    bus((1 << L_SEL), 8'h04, 1'b0);
    chk("R8", "irq on selection", irq, 1);
    rd(3'd5, v);
    chk("R11", "irq mirror bit4", v[4], 1);
    bus(9'h000, 8'h00, 1'b0);
    chk("R8", "irq held", irq, 1);
    rd(3'd7, v);
    chk("R11", "irq cleared by read 7", irq, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    wr(3'd2, 8'h30);
    bus((1 << L_REQ), 8'h01, 1'b0);
    rd(3'd5, v);
    chk("R9", "good byte no error", v[5], 0);
    bus(9'h000, 8'h01, 1'b0);
    bus((1 << L_REQ), 8'h01, 1'b1);
    rd(3'd5, v);
    chk("R9", "bad byte flag", v[5], 1);
    chk("R9", "bad byte irq", irq, 1);
    rd(3'd7, v);
    rd(3'd5, v);
    chk("R11", "parity flag cleared", v[5], 0);
    chk("R11", "irq cleared", irq, 0);
    bus(9'h000, 8'h01, 1'b1);
    wr(3'd2, 8'h20);
    bus((1 << L_REQ), 8'h01, 1'b1);
    rd(3'd5, v);
    chk("R9", "flag without irq enable", v[5], 1);
    chk("R9", "no irq without enable", irq, 0);
    rd(3'd7, v);
    bus(9'h000, 8'h01, 1'b1);
    wr(3'd2, 8'h00);
    bus((1 << L_REQ), 8'h01, 1'b1);
    rd(3'd5, v);
    chk("R9", "check disabled", v[5], 0);
    bus(9'h000, 8'h00, 1'b0);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    bus((1 << L_BSY), 8'h00, 1'b0);
    bus(9'h000, 8'h00, 1'b0);
    rd(3'd5, v);
    chk("R10", "no error without monitor", {v[4], v[2]}, 2'b00);
    wr(3'd2, 8'h04);
    bus((1 << L_BSY), 8'h00, 1'b0);
    chk("R10", "no irq while BSY held", irq, 0);
    bus(9'h000, 8'h00, 1'b0);
    rd(3'd5, v);
    chk("R10", "busy error and irq", {v[4], v[2]}, 2'b11);
    rd(3'd7, v);
    rd(3'd5, v);
    chk("R11", "busy error cleared", {v[4], v[2]}, 2'b00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_arb;
    logic [7:0] v;
    wr(3'd2, 8'h01);
    bus((1 << L_BSY), 8'h00, 1'b0);
    rd(3'd1, v);
    chk("R12", "arb in progress", v[6:5], 2'b10);
    bus((1 << L_BSY) | (1 << L_SEL), 8'h00, 1'b0);
    rd(3'd1, v);
    chk("R12", "arb lost latched", v[5], 1);
    bus(9'h000, 8'h00, 1'b0);
    rd(3'd1, v);
    chk("R12", "arb lost held, busy gone", v[6:5], 2'b01);
    wr(3'd2, 8'h00);
    rd(3'd1, v);
    chk("R12", "flags clear after arbitrate off", v, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_regs();
    t_icmd();
    t_drive();
    t_target();
    t_status();
    t_phase();
    t_select();
    t_parity();
    t_busy();
    t_arb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule